// File: doc/BRIEF.md
# Speed-Mode PHY Configuration Controller

This block sits between the host controller's speed-mode logic and the card-side PHY. Whenever software or the bus manager presents a new combination of timing mode, clock-rate class and bus width on its inputs and pulses `cfg_strobe`, the controller runs a short, fixed reconfiguration sequence. It decides whether the PHY has to be bypassed in slow mode, records whether the card is an SDIO device, rewrites the function-control word that selects double-rate or single-rate sampling, and finally asks the PHY initialization sequencer to re-initialize the PHY.

The function-control word is only rewritten while the card clock is gated off; the controller drops `card_clk_en`, updates the word and raises the enable again before it requests initialization. Legacy mode and any mode that ends up in slow mode skip the clock gating and the word update and go straight to the initialization request. A strobe whose rate class, width and mode all match the last applied request does nothing, and a strobe with a rate class of zero (clock stopped) only forgets the remembered rate so that the next non-zero request is always applied.

Top module: `spd_phy_cfg_ctrl`

## Requirements
- R1: After reset `busy`=0, `init_req`=0, `card_clk_en`=1, `slow_mode`=0, `sdio_mode`=0 and `func_ctrl`=32'h0000_0010 (single-rate with the data-async bit set).
- R2: Mode code 10 (hs400), when not in slow mode, sets `func_ctrl` to 32'h0001_FF00: data-lane double-rate bits [15:8] all ones, command double-rate bit 16 set, data-async bit 4 clear, all other bits zero.
- R3: Mode codes 7 (ddr50) and 8 (ddr52), when not in slow mode, set `func_ctrl` to 32'h0001_FF10: bits [15:8], bit 16 and bit 4 set.
- R4: Every other mode code (1..6, 9 and the unused codes 11..15), when not in slow mode and not legacy (code 0), sets `func_ctrl` to 32'h0000_0010: bits [15:8] and bit 16 clear, bit 4 set.
- R5: On the full path `card_clk_en` is low for exactly two sampled cycles (3 and 4 after the accepting edge), `func_ctrl` changes only while it is low, and it is high again when `init_req` rises.
- R6: When `clk_high`=1 (card clock above 52 MHz), `slow_mode` is set to 0 whatever the other inputs.
- R7: With `clk_high`=0 and mode code 0 (legacy), `slow_mode` takes the value of `slow_ok`.
- R8: With `clk_high`=0 and mode codes 1 (mmc-hs), 2 (sd-hs), 3 (sdr12) or 4 (sdr25), `slow_mode` = `sdio_card` OR `slow_ok`; for every other non-legacy code it is 0.
- R9: Legacy mode and slow mode leave `func_ctrl` and the clock enable untouched; legacy mode also leaves `sdio_mode` unchanged, while every other mode copies `sdio_card` into `sdio_mode`.
- R10: A strobe whose rate class, bus width and mode code all equal the last applied values starts no sequence: `busy` and `init_req` stay low.
- R11: A strobe with `rate_class`=0 starts no sequence and clears only the remembered rate, so a following strobe with the previously applied rate, width and mode starts a sequence.
- R12: `init_req` is a one-cycle pulse, due 1 cycle after the accepting edge for legacy, 2 cycles for slow mode and 5 cycles on the full path; `busy` stays high from the accepting edge until the edge that samples `init_done` high after the pulse.
- R13: A strobe that arrives while `busy` is high is ignored: it neither starts a second sequence nor alters the remembered request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_code | input | 4 | Requested timing mode (0 legacy, 1 mmc-hs, 2 sd-hs, 3 sdr12, 4 sdr25, 5 sdr50, 6 sdr104, 7 ddr50, 8 ddr52, 9 hs200, 10 hs400) |
| clk_high | input | 1 | Card clock is above 52 MHz |
| sdio_card | input | 1 | Attached card is an SDIO device |
| slow_ok | input | 1 | Board allows the slow bypass mode |
| rate_class | input | RATE_W (8) | Card clock rate class; 0 means clock stopped |
| bus_width | input | BW_W (2) | Requested bus width code |
| cfg_strobe | input | 1 | Apply the request presented on the inputs |
| init_done | input | 1 | PHY initialization sequencer has finished |
| func_ctrl | output | 32 | Function-control word for the PHY |
| slow_mode | output | 1 | PHY bypass (slow) mode |
| sdio_mode | output | 1 | PHY SDIO mode |
| card_clk_en | output | 1 | Card clock enable |
| init_req | output | 1 | One-cycle request to the PHY initialization sequencer |
| busy | output | 1 | Reconfiguration sequence in progress |

## Verification
Counting the accepting edge as cycle 0, `sdio_mode` is due one cycle later, `slow_mode` two cycles later (one for legacy), the clock gate falls at cycle 3, the new `func_ctrl` appears at cycle 4 and the enable returns with `init_req` at cycle 5. The bench drives every stimulus on the falling edge and samples every output on the following falling edges into a per-cycle record, then compares each recorded cycle with the index predicted by its own model of the path (legacy, slow or full). The initialization sequencer is modelled by raising `init_done` one cycle after the pulse is seen, so the end of `busy` is predicted at two cycles after the pulse.

// File: rtl/spd_phy_pkg.sv
// Shared types and field positions for the speed-mode PHY configuration controller.
// Assumes a 32-bit function-control word whose double-rate and async fields sit at
// the positions below; the PHY decodes these positions.
package spd_phy_pkg;

    localparam int FUNC_W       = 32;
    localparam int DQ_LANES     = 8;
    localparam int DQ_DDR_LSB   = 8;
    localparam int CMD_DDR_BIT  = 16;
    localparam int DQ_ASYNC_BIT = 4;
    localparam int MODE_W       = 4;

    typedef enum logic [MODE_W-1:0] {
        SPD_LEGACY = 4'd0,
        SPD_MMC_HS = 4'd1,
        SPD_SD_HS  = 4'd2,
        SPD_SDR12  = 4'd3,
        SPD_SDR25  = 4'd4,
        SPD_SDR50  = 4'd5,
        SPD_SDR104 = 4'd6,
        SPD_DDR50  = 4'd7,
        SPD_DDR52  = 4'd8,
        SPD_HS200  = 4'd9,
        SPD_HS400  = 4'd10
    } spd_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SET_SDIO,
        ST_SLOW_CHECK,
        ST_CLK_OFF,
        ST_WRITE_FUNC,
        ST_CLK_ON,
        ST_INIT_REQ,
        ST_WAIT_DONE
    } seq_state_e;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic              clk_high;
        logic              sdio_card;
        logic              slow_ok;
    } phy_req_t;

    // Build a function-control word from the three mode-dependent controls.
    function automatic logic [FUNC_W-1:0] func_word(input logic dq_ddr,
                                                    input logic cmd_ddr,
                                                    input logic dq_async);
        logic [FUNC_W-1:0] w;
        w = '0;
        for (int i = 0; i < DQ_LANES; i++) begin
            w[DQ_DDR_LSB + i] = dq_ddr;
        end
        w[CMD_DDR_BIT]  = cmd_ddr;
        w[DQ_ASYNC_BIT] = dq_async;
        return w;
    endfunction

    localparam logic [FUNC_W-1:0] FUNC_RESET = func_word(1'b0, 1'b0, 1'b1);

endpackage

// File: rtl/spd_req_tracker.sv
// Remembers the last applied rate class, bus width and mode code and decides
// whether a strobe starts a new sequence. Assumes the sequencer takes the start
// pulse in the same cycle it is raised (only while idle). A zero rate class only
// clears the remembered rate, so any later non-zero rate never matches it.
module spd_req_tracker #(
    parameter int RATE_W = 8,
    parameter int BW_W   = 2,
    parameter int MODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic              idle,
    input  logic [RATE_W-1:0] rate,
    input  logic [BW_W-1:0]   width,
    input  logic [MODE_W-1:0] mode,
    output logic              start
);

    logic [RATE_W-1:0] last_rate;
    logic [BW_W-1:0]   last_width;
    logic [MODE_W-1:0] last_mode;
    logic              rate_zero;
    logic              same_req;
    logic              take;

    // Classify the presented request against the remembered one.
    always_comb begin
        rate_zero = (rate == '0);
        same_req  = (rate == last_rate) && (width == last_width) && (mode == last_mode);
        take      = strobe && idle;
        start     = take && !rate_zero && !same_req;
    end

    // Update the record when a sequence starts or the clock is reported stopped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_rate  <= '0;
            last_width <= '0;
            last_mode  <= '0;
        end else if (take && rate_zero) begin
            last_rate <= '0;
        end else if (start) begin
            last_rate  <= rate;
            last_width <= width;
            last_mode  <= mode;
        end
    end

endmodule

// File: rtl/spd_mode_rules.sv
// Pure decode of a latched request: slow-mode decision, legacy flag and the
// function-control word the mode calls for. Assumes clk_high means above 52 MHz.
module spd_mode_rules
    import spd_phy_pkg::*;
(
    input  phy_req_t          req,
    output logic              slow_want,
    output logic              is_legacy,
    output logic [FUNC_W-1:0] func_target
);

    logic single_low;

    // Slow-mode rule: never above 52 MHz, board choice in legacy, card type in low single-rate modes.
    always_comb begin
        is_legacy  = (req.mode == SPD_LEGACY);
        single_low = (req.mode == SPD_MMC_HS) || (req.mode == SPD_SD_HS) ||
                     (req.mode == SPD_SDR12)  || (req.mode == SPD_SDR25);
        if (req.clk_high) begin
            slow_want = 1'b0;
        end else if (is_legacy) begin
            slow_want = req.slow_ok;
        end else if (single_low) begin
            slow_want = req.sdio_card || req.slow_ok;
        end else begin
            slow_want = 1'b0;
        end
    end

    // Function-control word per mode: strobe-sampled HS400, async double-rate, or single-rate.
    always_comb begin
        case (req.mode)
            SPD_HS400:            func_target = func_word(1'b1, 1'b1, 1'b0);
            SPD_DDR50, SPD_DDR52: func_target = func_word(1'b1, 1'b1, 1'b1);
            default:              func_target = func_word(1'b0, 1'b0, 1'b1);
        endcase
    end

endmodule

// File: rtl/spd_seq_engine.sv
// Reconfiguration state machine. Latches the request on start, sets SDIO mode,
// applies the slow-mode rule, gates the card clock around the function-control
// write, then pulses the init request and waits for the init sequencer.
// Assumes init_done is only meaningful after init_req has been pulsed.
module spd_seq_engine
    import spd_phy_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  phy_req_t          req_in,
    input  logic              init_done,
    output logic [FUNC_W-1:0] func_ctrl,
    output logic              slow_mode,
    output logic              sdio_mode,
    output logic              card_clk_en,
    output logic              init_req,
    output logic              busy
);

    seq_state_e        state;
    phy_req_t          req_q;
    logic              slow_want;
    logic              is_legacy;
    logic [FUNC_W-1:0] func_target;

    spd_mode_rules u_rules (
        .req         (req_q),
        .slow_want   (slow_want),
        .is_legacy   (is_legacy),
        .func_target (func_target)
    );

    // Status decode straight from the state.
    always_comb begin
        busy     = (state != ST_IDLE);
        init_req = (state == ST_INIT_REQ);
    end

    // Sequence the reconfiguration steps and update the PHY-facing registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            req_q       <= '0;
            sdio_mode   <= 1'b0;
            slow_mode   <= 1'b0;
            func_ctrl   <= FUNC_RESET;
            card_clk_en <= 1'b1;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        req_q <= req_in;
                        state <= (req_in.mode == SPD_LEGACY) ? ST_SLOW_CHECK : ST_SET_SDIO;
                    end
                end
                ST_SET_SDIO: begin
                    sdio_mode <= req_q.sdio_card;
                    state     <= ST_SLOW_CHECK;
                end
                ST_SLOW_CHECK: begin
                    slow_mode <= slow_want;
                    state     <= (slow_want || is_legacy) ? ST_INIT_REQ : ST_CLK_OFF;
                end
                ST_CLK_OFF: begin
                    card_clk_en <= 1'b0;
                    state       <= ST_WRITE_FUNC;
                end
                ST_WRITE_FUNC: begin
                    func_ctrl <= func_target;
                    state     <= ST_CLK_ON;
                end
                ST_CLK_ON: begin
                    card_clk_en <= 1'b1;
                    state       <= ST_INIT_REQ;
                end
                ST_INIT_REQ: begin
                    state <= ST_WAIT_DONE;
                end
                ST_WAIT_DONE: begin
                    if (init_done) begin
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/spd_phy_cfg_ctrl.sv
// Top of the speed-mode PHY configuration controller. Packs the request inputs,
// filters repeated or clock-stopped strobes, and runs the reconfiguration engine.
// Assumes all inputs are synchronous to clk and held stable while cfg_strobe is high.
module spd_phy_cfg_ctrl
    import spd_phy_pkg::*;
#(
    parameter int RATE_W = 8,
    parameter int BW_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_code,
    input  logic              clk_high,
    input  logic              sdio_card,
    input  logic              slow_ok,
    input  logic [RATE_W-1:0] rate_class,
    input  logic [BW_W-1:0]   bus_width,
    input  logic              cfg_strobe,
    input  logic              init_done,
    output logic [FUNC_W-1:0] func_ctrl,
    output logic              slow_mode,
    output logic              sdio_mode,
    output logic              card_clk_en,
    output logic              init_req,
    output logic              busy
);

    phy_req_t req_in;
    logic     start;

    // Gather the request fields into one bundle.
    always_comb begin
        req_in.mode      = mode_code;
        req_in.clk_high  = clk_high;
        req_in.sdio_card = sdio_card;
        req_in.slow_ok   = slow_ok;
    end

    spd_req_tracker #(
        .RATE_W (RATE_W),
        .BW_W   (BW_W),
        .MODE_W (MODE_W)
    ) u_track (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (cfg_strobe),
        .idle   (!busy),
        .rate   (rate_class),
        .width  (bus_width),
        .mode   (mode_code),
        .start  (start)
    );

    spd_seq_engine u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .req_in      (req_in),
        .init_done   (init_done),
        .func_ctrl   (func_ctrl),
        .slow_mode   (slow_mode),
        .sdio_mode   (sdio_mode),
        .card_clk_en (card_clk_en),
        .init_req    (init_req),
        .busy        (busy)
    );

endmodule

// File: rtl/spd_phy_cfg_chk.sv
// Property checker for the speed-mode PHY configuration controller, bound to the top.
// Observes ports only.
module spd_phy_cfg_chk
    import spd_phy_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [FUNC_W-1:0] func_ctrl,
    input logic              slow_mode,
    input logic              card_clk_en,
    input logic              init_req,
    input logic              busy
);

    localparam logic [FUNC_W-1:0] W_HS400 = func_word(1'b1, 1'b1, 1'b0);
    localparam logic [FUNC_W-1:0] W_DDR   = func_word(1'b1, 1'b1, 1'b1);
    localparam logic [FUNC_W-1:0] W_SDR   = func_word(1'b0, 1'b0, 1'b1);

    // R2 R3 R4: only the three legal function-control words ever appear.
    a_r2_func_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (func_ctrl == W_HS400) || (func_ctrl == W_DDR) || (func_ctrl == W_SDR));

    // R5: the function-control word changes only while the card clock is gated.
    a_r5_func_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(func_ctrl) |-> !card_clk_en);

    // R5: the card clock is running whenever the controller is idle.
    a_r5_clk_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> card_clk_en);

    // R9: the clock is never gated while slow mode is in force.
    a_r9_no_gate_slow: assert property (@(posedge clk) disable iff (!rst_n)
        !card_clk_en |-> !slow_mode);

    // R12: the init request is a single-cycle pulse raised only while busy.
    a_r12_init_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        init_req |=> !init_req);

    a_r12_init_busy: assert property (@(posedge clk) disable iff (!rst_n)
        init_req |-> (busy && card_clk_en));

    // R6 R7 R8: slow mode only moves during a sequence.
    a_r7_slow_in_seq: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(slow_mode) |-> busy);

endmodule

bind spd_phy_cfg_ctrl spd_phy_cfg_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .func_ctrl   (func_ctrl),
    .slow_mode   (slow_mode),
    .card_clk_en (card_clk_en),
    .init_req    (init_req),
    .busy        (busy)
);

// File: tb/tb_spd_phy_cfg_ctrl.sv
module tb_spd_phy_cfg_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NCYC       = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  mode_code = '0;
    logic        clk_high = 1'b0;
    logic        sdio_card = 1'b0;
    logic        slow_ok = 1'b0;
    logic [7:0]  rate_class = '0;
    logic [1:0]  bus_width = '0;
    logic        cfg_strobe = 1'b0;
    logic        init_done = 1'b0;
    logic [31:0] func_ctrl;
    logic        slow_mode, sdio_mode, card_clk_en, init_req, busy;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    // bench-side model state
    logic [31:0] m_func = 32'h0000_0010;
    logic        m_sdio = 1'b0;
    logic        m_slow = 1'b0;
    logic [7:0]  m_rate = '0;
    logic [1:0]  m_width = '0;
    logic [3:0]  m_mode = '0;

    logic        s_en  [0:NCYC-1];
    logic        s_req [0:NCYC-1];
    logic        s_busy[0:NCYC-1];
    logic [31:0] s_func[0:NCYC-1];

    always #(CLK_PERIOD/2) clk = ~clk;

    spd_phy_cfg_ctrl dut (
        .clk(clk), .rst_n(rst_n), .mode_code(mode_code), .clk_high(clk_high),
        .sdio_card(sdio_card), .slow_ok(slow_ok), .rate_class(rate_class),
        .bus_width(bus_width), .cfg_strobe(cfg_strobe), .init_done(init_done),
        .func_ctrl(func_ctrl), .slow_mode(slow_mode), .sdio_mode(sdio_mode),
        .card_clk_en(card_clk_en), .init_req(init_req), .busy(busy)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_word(input logic [3:0] m);
        if (m == 4'd10) return 32'h0001_FF00;
        if (m == 4'd7 || m == 4'd8) return 32'h0001_FF10;
        return 32'h0000_0010;
    endfunction

    function automatic logic exp_slow(input logic [3:0] m, input logic hi, input logic sd, input logic ok);
        if (hi) return 1'b0;
        if (m == 4'd0) return ok;
        if (m >= 4'd1 && m <= 4'd4) return sd | ok;
        return 1'b0;
    endfunction

    // Apply one request, record NCYC sampled cycles and check them against the model.
    // repulse: raise a second, different strobe while busy (R13).
    task automatic run_case(input logic [3:0] m, input logic hi, input logic sd, input logic ok,
                            input logic [7:0] r, input logic [1:0] w, input bit repulse);
        int  req_idx;
        int  n_req, n_low, n_busy, first_low;
        bit  runs;
        logic req_prev;
        logic sl;
        runs = (r != 0) && !(r == m_rate && w == m_width && m == m_mode);
        sl   = exp_slow(m, hi, sd, ok);
        if (!runs) req_idx = -1;
        else if (m == 4'd0) req_idx = 1;
        else if (sl) req_idx = 2;
        else req_idx = 5;
        @(negedge clk);
        mode_code = m; clk_high = hi; sdio_card = sd; slow_ok = ok;
        rate_class = r; bus_width = w; cfg_strobe = 1'b1;
        req_prev = 1'b0;
        for (int i = 0; i < NCYC; i++) begin
            @(negedge clk);
            cfg_strobe = 1'b0;
            if (repulse && i == 2) begin
                cfg_strobe = 1'b1; mode_code = m ^ 4'd1; bus_width = ~w;
            end
            if (repulse && i == 3) begin
                mode_code = m; bus_width = w;
            end
            s_en[i] = card_clk_en; s_req[i] = init_req;
            s_busy[i] = busy; s_func[i] = func_ctrl;
            init_done = req_prev;
            req_prev  = init_req;
        end
        init_done = 1'b0;
        // model update
        if (r == 0) m_rate = '0;
        if (runs) begin
            m_rate = r; m_width = w; m_mode = m;
            if (m != 4'd0) m_sdio = sd;
            m_slow = sl;
            if (m != 4'd0 && !sl) m_func = exp_word(m);
        end
        n_req = 0; n_low = 0; n_busy = 0; first_low = -1;
        for (int i = 0; i < NCYC; i++) begin
            if (s_req[i]) n_req++;
            if (!s_en[i]) begin n_low++; if (first_low < 0) first_low = i; end
            if (s_busy[i]) n_busy++;
        end
        // R12 timing of the pulse and busy window (R10/R11/R13 when no run is due)
        chk("R12 init_req count", n_req, (req_idx >= 0) ? 1 : 0);
        if (req_idx >= 0) chk("R12 init_req cycle", s_req[req_idx], 1);
        chk("R12 busy window", n_busy, (req_idx >= 0) ? req_idx + 2 : 0);
        // R5 clock gate placement and function word during the gate
        chk("R5 clk gate cycles", n_low, (req_idx == 5) ? 2 : 0);
        if (req_idx == 5) begin
            chk("R5 gate start", first_low, 3);
            chk("R5 func while gated", s_func[4], exp_word(m));
            chk("R5 clk back at req", s_en[5], 1);
        end
        // final register values: R2 R3 R4 R6 R7 R8 R9
        chk(hi ? "R6 slow_mode" : (m == 0 ? "R7 slow_mode" : "R8 slow_mode"), slow_mode, m_slow);
        chk("R9 sdio_mode", sdio_mode, m_sdio);
        chk(m == 10 ? "R2 func" : ((m == 7 || m == 8) ? "R3 func" : "R4 func"), func_ctrl, m_func);
    endtask

    initial begin
        int cnt;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", busy, 0);
        chk("R1 init_req", init_req, 0);
        chk("R1 card_clk_en", card_clk_en, 1);
        chk("R1 slow_mode", slow_mode, 0);
        chk("R1 sdio_mode", sdio_mode, 0);
        chk("R1 func_ctrl", func_ctrl, 32'h0000_0010);
        // sweep every mode with every flag combination (R2..R9, R12)
        cnt = 0;
        for (int m = 0; m <= 10; m++)
            for (int f = 0; f < 8; f++) begin
                cnt++;
                run_case(m[3:0], f[2], f[1], f[0], f[2] ? 8'd200 : 8'd50, cnt[1:0], 1'b0);
            end
        // unused code is single-rate (R4)
        run_case(4'd13, 1'b1, 1'b0, 1'b0, 8'd200, 2'd1, 1'b0);
        // DDR after single-rate then HS400 (R3, R2)
        run_case(4'd7, 1'b1, 1'b0, 1'b0, 8'd100, 2'd2, 1'b0);
        run_case(4'd10, 1'b1, 1'b0, 1'b0, 8'd200, 2'd3, 1'b0);
        // R10: identical request does nothing
        run_case(4'd10, 1'b1, 1'b0, 1'b0, 8'd200, 2'd3, 1'b0);
        // R11: clock stopped then same request again runs
        run_case(4'd10, 1'b1, 1'b0, 1'b0, 8'd0, 2'd3, 1'b0);
        run_case(4'd10, 1'b1, 1'b0, 1'b0, 8'd200, 2'd3, 1'b0);
        // R13: strobe during busy ignored, record keeps first request
        run_case(4'd8, 1'b1, 1'b1, 1'b0, 8'd150, 2'd0, 1'b1);
        run_case(4'd8, 1'b1, 1'b1, 1'b0, 8'd150, 2'd0, 1'b0);
        // legacy keeps sdio mode after an SDIO run (R9)
        run_case(4'd0, 1'b0, 1'b0, 1'b1, 8'd20, 2'd1, 1'b0);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule